// File: doc/BRIEF.md
# Serial Byte Receiver with Stream Output

This block recovers bytes from an asynchronous serial line and hands each one to downstream logic over a valid/ready stream port carrying 8 data bits. Each frame begins with a low start bit. Eight data bits follow, least significant bit first. An optional parity bit comes next, and a high stop bit closes the frame. The clock frequency, baud rate, parity mode and receive buffer size are all fixed at compile time.

The clock-to-baud ratio does not have to be an integer. A phase accumulator places every half-bit instant at the clock count nearest its ideal time, so individual bits span either the floor or the ceiling of the ratio, and the error never builds up across a frame. Each bit is sampled at its middle.

With no buffer, every good byte appears for a single cycle and the ready input is not looked at. With a buffer, bytes wait until they are taken, in arrival order. A byte that arrives while the buffer is full is dropped, and a one-cycle overflow pulse reports the loss.

Top module: `serial_byte_rx`

## Requirements
- R1: While `rst_n` is low (synchronous, active low) and in the cycle after it rises, `m_valid` and `overflow` are low.
- R2: The byte is rebuilt from the eight data bits that follow the start bit, taking the first data bit as bit 0 of `m_data`, and it is correct for data patterns 0x00, 0xFF, 0xA5 and 0x3C.
- R3: With `PARITY` set to odd, the bit after the data makes the count of ones among the data and parity bits odd. With `PARITY` set to even, that count is even. A frame whose parity bit breaks this rule produces no byte.
- R4: A frame whose stop bit is sampled low produces no byte, and the next good frame is received normally.
- R5: A low pulse shorter than half a bit, with the line high at the middle of the start bit, produces no byte. The receiver then returns to idle and takes the next frame.
- R6: With `BUF_SEL` = 0 there is no buffer. Each good byte raises `m_valid` for exactly one cycle whatever the level of `m_ready`, and `overflow` stays low.
- R7: With a buffer (`BUF_SEL` > 0), a byte is held on `m_data` with `m_valid` high until `m_valid` and `m_ready` are both high at a clock edge. In the following cycle the next stored byte is shown, or `m_valid` is low if nothing is left. Bytes leave in arrival order.
- R8: `BUF_SEL` values 1 and 2 give room for 4 bytes, and a value n of 3 or more gives room for 2^(n-1) bytes. A byte completed while the buffer is full is discarded and `overflow` is high for exactly one cycle. The bytes already stored are unaffected.
- R9: Bit instants come from a fractional divider. With a ratio of 5 MHz to 115200 baud, bit k ends at the clock nearest k × 43.40 cycles (43, 87, 130, 174, …, 434). A frame timed this way is received, and with even parity and no buffer `m_valid` rises 457 to 463 clocks after the start bit is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| m_ready | input | 1 | Downstream accepts the byte on offer |
| m_valid | output | 1 | A received byte is on `m_data` |
| m_data | output | 8 | Received byte |
| overflow | output | 1 | One-cycle pulse when a byte is dropped on a full buffer |

## Verification
Each result has a fixed cycle at which it is due, and the bench drives the line from a clock-counting model of the bit boundaries so that it knows these cycles.

- **Unbuffered byte:** the pulse comes two synchronizer stages, one detection cycle and the tick count to the middle of the stop bit after the start edge (460 clocks here), plus one output register. The bench time-stamps the pulse and checks it against a small window.
- **Buffered byte:** the byte shows up two cycles after the frame completes.
- **Pop:** a pop takes effect at the edge where ready is high, so the next byte, or the drop of valid, is checked on the following falling edge.
- **Dropped frames:** frames expected to be ignored are judged only after the full frame and an idle gap have passed.

All outputs are sampled on the falling clock edge, away from the edges where they change.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } parity_e;

  // Buffer size selected by the BUF_SEL parameter; 0 means no buffer.
  function automatic int buf_depth(input int sel);
    if (sel <= 0) return 0;
    if (sel <= 2) return 4;
    return 1 << (sel - 1);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);

  // sh[STAGES-1] is the synchronized level; sh[STAGES] holds the previous one.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign fall  = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/rx_half_tick.sv
module rx_half_tick #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned BAUD_HZ = 115_200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);

  // Phase accumulator that advances by 2*BAUD each clock and wraps at CLK.
  // Each wrap marks a half-bit instant. Seeding with BAUD rounds every
  // instant to the nearest clock.
  localparam int PW = $clog2(CLK_HZ + 2 * BAUD_HZ + 1) + 1;
  localparam logic [PW-1:0] LIM  = PW'(CLK_HZ);
  localparam logic [PW-1:0] STEP = PW'(2 * BAUD_HZ);
  localparam logic [PW-1:0] SEED = PW'(BAUD_HZ);

  logic [PW-1:0] ph;
  logic [PW-1:0] ph_sum;

  assign ph_sum = ph + STEP;
  assign tick   = run && (ph_sum >= LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) ph <= SEED;
    else if (run)          ph <= tick ? (ph_sum - LIM) : ph_sum;
  end

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter parity_e PARITY = PAR_NONE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic       fall,
  input  logic       tick,
  output logic       run,
  output logic       restart,
  output logic [7:0] data,
  output logic       done
);

  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  // Slot 0 is the start bit, slots 1..8 the data, then parity (if any), then stop.
  localparam logic [3:0] STOP_SLOT = (PARITY == PAR_NONE) ? 4'd9 : 4'd10;

  st_e        state;
  logic [4:0] hcnt;
  logic [4:0] hnext;
  logic [3:0] slot;
  logic [7:0] shreg;
  logic       par_bit;
  logic       par_ok;

  assign hnext   = hcnt + 5'd1;
  assign slot    = hnext[4:1];
  assign run     = (state == ST_BUSY);
  assign restart = (state == ST_IDLE) && fall;

  always_comb begin
    if (PARITY == PAR_NONE) par_ok = 1'b1;
    else                    par_ok = ((^{shreg, par_bit}) == (PARITY == PAR_ODD));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hcnt    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      data    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state <= ST_BUSY;
            hcnt  <= '0;
          end
        end
        ST_BUSY: begin
          if (tick) begin
            hcnt <= hnext;
            if (hnext[0]) begin
              if (slot == 4'd0) begin
                if (level) state <= ST_IDLE;
              end else if (slot <= 4'd8) begin
                shreg <= {level, shreg[7:1]};
              end else if (slot == STOP_SLOT) begin
                state <= ST_IDLE;
                if (level && par_ok) begin
                  data <= shreg;
                  done <= 1'b1;
                end
              end else begin
                par_bit <= level;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       dropped
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL = (AW + 1)'(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] mem_cnt;
  logic [AW:0] occ;
  logic        pop, accept, fetch;

  assign pop    = out_valid && out_ready;
  assign accept = push && (occ != FULL);
  assign fetch  = (!out_valid || pop) && (mem_cnt != '0);

  // Storage array without reset, written and read on the clock.
  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (fetch) out_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      mem_cnt   <= '0;
      occ       <= '0;
      out_valid <= 1'b0;
      dropped   <= 1'b0;
    end else begin
      dropped <= push && (occ == FULL);
      if (accept) wp <= wp + 1'b1;
      if (fetch)  rp <= rp + 1'b1;
      mem_cnt <= mem_cnt + (AW + 1)'(accept) - (AW + 1)'(fetch);
      occ     <= occ + (AW + 1)'(accept) - (AW + 1)'(pop);
      if (fetch)    out_valid <= 1'b1;
      else if (pop) out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned BAUD_HZ = 115_200,
  parameter parity_e     PARITY  = PAR_NONE,
  parameter int          BUF_SEL = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       overflow
);

  localparam int DEPTH = buf_depth(BUF_SEL);

  logic       level, fall, tick, run, restart, done;
  logic [7:0] byte_q;

  rx_line_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .level (level),
    .fall  (fall)
  );

  rx_half_tick #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (run),
    .tick    (tick)
  );

  rx_frame_fsm #(.PARITY(PARITY)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (level),
    .fall    (fall),
    .tick    (tick),
    .run     (run),
    .restart (restart),
    .data    (byte_q),
    .done    (done)
  );

  if (DEPTH == 0) begin : g_direct
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m_valid  <= 1'b0;
        m_data   <= '0;
        overflow <= 1'b0;
      end else begin
        m_valid  <= done;
        overflow <= 1'b0;
        if (done) m_data <= byte_q;
      end
    end
  end else begin : g_buffered
    rx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (done),
      .push_data (byte_q),
      .out_ready (m_ready),
      .out_valid (m_valid),
      .out_data  (m_data),
      .dropped   (overflow)
    );
  end

endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk #(
  parameter int BUF_SEL = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       m_ready,
  input logic       m_valid,
  input logic [7:0] m_data,
  input logic       overflow
);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!m_valid && !overflow));

  a_r8_overflow_single: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> !overflow);

  if (BUF_SEL == 0) begin : g_direct
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |=> !m_valid);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !overflow);
  end else begin : g_buffered
    a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  end

endmodule

bind serial_byte_rx serial_byte_rx_chk #(.BUF_SEL(BUF_SEL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_ready  (m_ready),
  .m_valid  (m_valid),
  .m_data   (m_data),
  .overflow (overflow)
);

// File: tb/test_serial_byte_rx.sv
module test_serial_byte_rx;
  import serial_rx_pkg::*;

  localparam int unsigned CLK_HZ  = 5_000_000;
  localparam int unsigned BAUD_HZ = 115_200;
  localparam int GAP = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_a = 1'b1, line_b = 1'b1;
  logic rdy_a = 1'b0, rdy_b = 1'b0;
  logic va, vb, ova, ovb;
  logic [7:0] da, db;

  int checks = 0, errors = 0;
  int cyc = 0, start_cyc = 0;
  int b_cnt = 0, b_cyc = 0, a_ovf_cnt = 0;
  logic [7:0] b_last = '0;
  bit done_flag = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Buffered instance: odd parity, room for 4 bytes.
  serial_byte_rx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .PARITY(PAR_ODD), .BUF_SEL(1))
    i_serial_byte_rx (.clk(clk), .rst_n(rst_n), .rx_line(line_a), .m_ready(rdy_a),
                      .m_valid(va), .m_data(da), .overflow(ova));

  // Unbuffered instance: even parity.
  serial_byte_rx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .PARITY(PAR_EVEN), .BUF_SEL(0))
    i_serial_byte_rx_nb (.clk(clk), .rst_n(rst_n), .rx_line(line_b), .m_ready(rdy_b),
                         .m_valid(vb), .m_data(db), .overflow(ovb));

  always @(negedge clk) begin
    if (vb) begin
      b_cnt  = b_cnt + 1;
      b_last = db;
      b_cyc  = cyc;
    end
    if (ova) a_ovf_cnt = a_ovf_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bound(input int k);
    return int'((2 * longint'(k) * longint'(CLK_HZ) + longint'(BAUD_HZ)) /
                (2 * longint'(BAUD_HZ)));
  endfunction

  task automatic drive(input bit to_b, input logic v);
    if (to_b) line_b = v;
    else      line_a = v;
  endtask

  // par: 0 none, 1 odd, 2 even. Called at a falling edge.
  task automatic send(input bit to_b, input logic [7:0] val, input int par,
                      input bit bad_par, input bit bad_stop);
    logic [10:0] bits;
    logic p;
    int nb;
    p = (par == 1) ? ~^val : ^val;
    if (bad_par) p = ~p;
    bits = '1;
    bits[0] = 1'b0;
    bits[8:1] = val;
    if (par != 0) begin
      bits[9] = p; bits[10] = ~bad_stop; nb = 11;
    end else begin
      bits[9] = ~bad_stop; nb = 10;
    end
    start_cyc = cyc;
    for (int k = 0; k < nb; k++) begin
      drive(to_b, bits[k]);
      repeat (bound(k + 1) - bound(k)) @(negedge clk);
    end
    drive(to_b, 1'b1);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic pop_a;
    rdy_a = 1'b1;
    @(negedge clk);
    rdy_a = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(!va && !vb, "R1", "valid during reset", int'(va | vb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!va && !vb && !ova && !ovb, "R1", "outputs after reset",
          int'(va | vb | ova | ovb), 0);
  endtask

  task automatic t_patterns;
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    for (int i = 0; i < 4; i++) begin
      b_cnt = 0;
      send(1'b1, pats[i], 2, 1'b0, 1'b0);
      check(b_cnt == 1, "R6", "single valid cycle", b_cnt, 1);
      check(b_last == pats[i], "R2", "byte value", b_last, pats[i]);
      if (i == 0)
        check((b_cyc - start_cyc) >= 457 && (b_cyc - start_cyc) <= 463, "R9",
              "valid latency", b_cyc - start_cyc, 460);
    end
    check(ovb == 1'b0, "R6", "no overflow unbuffered", ovb, 0);
  endtask

  task automatic t_parity;
    b_cnt = 0;
    send(1'b1, 8'h5B, 2, 1'b1, 1'b0);
    check(b_cnt == 0, "R3", "even parity error dropped", b_cnt, 0);
    send(1'b0, 8'h5B, 1, 1'b1, 1'b0);
    check(va == 1'b0, "R3", "odd parity error dropped", va, 0);
    send(1'b0, 8'h5B, 1, 1'b0, 1'b0);
    check(va == 1'b1 && da == 8'h5B, "R3", "odd parity good byte", da, 8'h5B);
    pop_a();
    check(va == 1'b0, "R7", "empty after pop", va, 0);
  endtask

  task automatic t_stop;
    b_cnt = 0;
    send(1'b1, 8'hC3, 2, 1'b0, 1'b1);
    check(b_cnt == 0, "R4", "bad stop dropped", b_cnt, 0);
    send(1'b1, 8'h96, 2, 1'b0, 1'b0);
    check(b_cnt == 1 && b_last == 8'h96, "R4", "good byte after bad stop", b_last, 8'h96);
  endtask

  task automatic t_false_start;
    b_cnt = 0;
    line_b = 1'b0;
    repeat (10) @(negedge clk);
    line_b = 1'b1;
    repeat (80) @(negedge clk);
    check(b_cnt == 0, "R5", "glitch ignored", b_cnt, 0);
    send(1'b1, 8'h5A, 2, 1'b0, 1'b0);
    check(b_cnt == 1 && b_last == 8'h5A, "R5", "frame after glitch", b_last, 8'h5A);
  endtask

  task automatic t_fifo_order;
    send(1'b0, 8'h11, 1, 1'b0, 1'b0);
    send(1'b0, 8'h22, 1, 1'b0, 1'b0);
    check(va == 1'b1 && da == 8'h11, "R7", "first byte held", da, 8'h11);
    repeat (20) @(negedge clk);
    check(va == 1'b1 && da == 8'h11, "R7", "still held without ready", da, 8'h11);
    pop_a();
    check(va == 1'b1 && da == 8'h22, "R7", "second byte after pop", da, 8'h22);
    pop_a();
    check(va == 1'b0, "R7", "valid low when empty", va, 0);
  endtask

  task automatic t_overflow;
    a_ovf_cnt = 0;
    for (int i = 0; i < 4; i++) send(1'b0, 8'h31 + 8'(i), 1, 1'b0, 1'b0);
    check(a_ovf_cnt == 0, "R8", "no overflow up to 4 bytes", a_ovf_cnt, 0);
    send(1'b0, 8'h35, 1, 1'b0, 1'b0);
    check(a_ovf_cnt == 1, "R8", "overflow pulse cycles", a_ovf_cnt, 1);
    for (int i = 0; i < 4; i++) begin
      check(va == 1'b1 && da == 8'h31 + 8'(i), "R8", "stored byte order", da, 8'h31 + i);
      pop_a();
    end
    check(va == 1'b0, "R8", "dropped byte absent", va, 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    repeat (5) @(negedge clk);
    t_patterns();
    t_parity();
    t_stop();
    t_false_start();
    t_fifo_order();
    t_overflow();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule